// File: doc/BRIEF.md
# Multi-Slot In-Order Retire Queue

This block tracks in-flight instructions in a circular queue of slots so that they leave the machine in program order. At allocation, an instruction asks for as many contiguous slots as it has micro-ops. The count is clamped to the queue size, and an instruction with no micro-ops still takes one slot. The index of the first slot it receives is returned as its token. Later, the execution side reports completion by presenting that token on the done port.

On every cycle the queue looks at the oldest entries, starting at the head. It retires those that have completed, in order, and stops at the first one that has not. It never retires more than a configured number per cycle, and a configured limit of zero lets every completed entry at the head leave in one cycle. Each retired instruction's identifier is presented on its own output lane with a valid bit. The free-slot count and an empty flag are always visible so that the front end can decide whether a request fits.

Top module: `retire_ring`

## Requirements
- R1: After reset the queue is empty. `free_slots` equals DEPTH, `empty` is 1, `alloc_token` is 0 and no `ret_valid` bit is set.
- R2: The slot count taken by a request is `alloc_uops`, raised to 1 when `alloc_uops` is 0 and lowered to DEPTH when `alloc_uops` exceeds DEPTH.
- R3: `alloc_token` shows the index of the next free slot (the tail). An accepted request advances it by the request's slot count modulo DEPTH. Otherwise it holds.
- R4: `alloc_ready` is 1 exactly when the request's slot count is at most `free_slots`. A request presented while `alloc_ready` is 0 changes no state.
- R5: On the edge after an accepted request, `free_slots` drops by its slot count. It also grows by the slot counts of the entries retired in the same cycle.
- R6: A done report marks an entry completed only if `done_token` is below DEPTH, names the first slot of a live entry, and that entry is not already completed. Any other done report has no effect.
- R7: Retirement runs strictly from the head. Lane 0 carries the oldest entry, and the lanes stop at the first live entry that is not completed, so the set `ret_valid` bits always form a run starting at lane 0.
- R8: At most RETIRE_MAX entries retire per cycle. With RETIRE_MAX = 0, up to DEPTH entries may retire in one cycle.
- R9: A completed entry is shown on a lane in the cycle after its done report, and its lane carries the identifier given at allocation. The head then moves past the entry's slot count on the next edge.
- R10: `empty` is 1 exactly when `free_slots` equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Allocation request |
| alloc_uops | input | UOP_W | Micro-op count of the request |
| alloc_id | input | ID_W | Identifier stored with the entry |
| alloc_ready | output | 1 | Request fits in the free slots |
| alloc_token | output | IDX_W | Tail index, the token of the next accepted request |
| done_valid | input | 1 | Completion report |
| done_token | input | IDX_W | Token of the completed entry |
| ret_valid | output | LANES | Per-lane retire valid |
| ret_id | output | LANES*ID_W | Per-lane retired identifier, lane k at bits k*ID_W upward |
| free_slots | output | CNT_W | Number of unoccupied slots |
| empty | output | 1 | No live entries |

## Verification
The checker assumes that allocation requests only fire with `alloc_ready` high. It also assumes that nothing outside the block moves the tail, so the slot arithmetic it tracks is the only source of change. Done reports are not assumed to be well formed. The stimulus deliberately mixes tokens of live entries with repeated reports, tokens that land inside an entry rather than at its first slot, and tokens beyond DEPTH, because the block must filter these itself. Micro-op counts are drawn from the full input range, so zero and oversize requests occur alongside normal ones, and requests that do not fit are presented while the queue is full to confirm that they leave no trace.

// File: rtl/retire_ring_pkg.sv
package retire_ring_pkg;

   // Slots consumed by a request: at least one, never more than the ring.
   function automatic int slots_for(input int uops, input int depth);
      if (uops == 0) return 1;
      if (uops > depth) return depth;
      return uops;
   endfunction

   // Modular advance of a ring index by at most one full turn.
   function automatic int ring_add(input int pos, input int step, input int depth);
      int sum;
      sum = pos + step;
      if (sum >= depth) sum = sum - depth;
      return sum;
   endfunction

endpackage

// File: rtl/retire_ring_store.sv
module retire_ring_store #(
   parameter int DEPTH = 12,
   parameter int ID_W  = 8,
   parameter int IDX_W = 4,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [ID_W-1:0]  wr_id,
   input  logic [CNT_W-1:0] wr_cnt,
   input  logic             mark_en,
   input  logic [IDX_W-1:0] mark_idx,
   input  logic [DEPTH-1:0] clr_mask,
   output logic [DEPTH-1:0] head_of_entry,
   output logic [DEPTH-1:0] finished,
   output logic [ID_W-1:0]  ent_id  [DEPTH],
   output logic [CNT_W-1:0] ent_cnt [DEPTH]
);

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic hit_wr;
      logic hit_mark;
      assign hit_wr   = wr_en && (wr_idx == IDX_W'(s));
      assign hit_mark = mark_en && (mark_idx == IDX_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            head_of_entry[s] <= 1'b0;
            finished[s]      <= 1'b0;
            ent_id[s]        <= '0;
            ent_cnt[s]       <= '0;
         end else if (hit_wr) begin
            head_of_entry[s] <= 1'b1;
            finished[s]      <= 1'b0;
            ent_id[s]        <= wr_id;
            ent_cnt[s]       <= wr_cnt;
         end else begin
            if (clr_mask[s]) head_of_entry[s] <= 1'b0;
            if (hit_mark)    finished[s]      <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/retire_ring_select.sv
module retire_ring_select
   import retire_ring_pkg::*;
#(
   parameter int DEPTH = 12,
   parameter int ID_W  = 8,
   parameter int IDX_W = 4,
   parameter int CNT_W = 4,
   parameter int LANES = 2
) (
   input  logic [IDX_W-1:0] head,
   input  logic [CNT_W-1:0] occupied,
   input  logic [DEPTH-1:0] head_of_entry,
   input  logic [DEPTH-1:0] finished,
   input  logic [ID_W-1:0]  ent_id  [DEPTH],
   input  logic [CNT_W-1:0] ent_cnt [DEPTH],
   output logic [LANES-1:0] lane_vld,
   output logic [ID_W-1:0]  lane_id [LANES],
   output logic [DEPTH-1:0] clr_mask,
   output logic [CNT_W-1:0] freed,
   output logic [IDX_W-1:0] head_nxt
);

   // Serial walk from the head: each lane depends on all older lanes.
   always_comb begin
      logic [IDX_W-1:0] pos;
      int used;
      int step;
      logic go;
      pos      = head;
      used     = 0;
      go       = 1'b1;
      lane_vld = '0;
      clr_mask = '0;
      for (int k = 0; k < LANES; k++) begin
         lane_id[k] = '0;
         step       = 0;
         if (go && (used < int'(occupied)) && head_of_entry[pos] && finished[pos]) begin
            lane_vld[k]   = 1'b1;
            lane_id[k]    = ent_id[pos];
            clr_mask[pos] = 1'b1;
            step          = int'(ent_cnt[pos]);
            used          = used + step;
            pos           = IDX_W'(ring_add(int'(pos), step, DEPTH));
         end else begin
            go = 1'b0;
         end
      end
      freed    = CNT_W'(used);
      head_nxt = pos;
   end

endmodule

// File: rtl/retire_ring.sv
module retire_ring
   import retire_ring_pkg::*;
#(
   parameter int DEPTH      = 12,
   parameter int ID_W       = 8,
   parameter int UOP_W      = 5,
   parameter int RETIRE_MAX = 2,
   localparam int IDX_W     = $clog2(DEPTH),
   localparam int CNT_W     = $clog2(DEPTH + 1),
   localparam int LANES     = (RETIRE_MAX == 0) ? DEPTH : RETIRE_MAX
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  alloc_valid,
   input  logic [UOP_W-1:0]      alloc_uops,
   input  logic [ID_W-1:0]       alloc_id,
   output logic                  alloc_ready,
   output logic [IDX_W-1:0]      alloc_token,
   input  logic                  done_valid,
   input  logic [IDX_W-1:0]      done_token,
   output logic [LANES-1:0]      ret_valid,
   output logic [LANES*ID_W-1:0] ret_id,
   output logic [CNT_W-1:0]      free_slots,
   output logic                  empty
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("retire_ring: DEPTH must be at least 2");
   end
   if (RETIRE_MAX < 0 || RETIRE_MAX > DEPTH) begin : g_bad_lanes
      $error("retire_ring: RETIRE_MAX must lie in 0..DEPTH");
   end
   if (ID_W < 1 || UOP_W < 1) begin : g_bad_width
      $error("retire_ring: ID_W and UOP_W must be positive");
   end

   logic [IDX_W-1:0] head_q, tail_q, head_nxt;
   logic [CNT_W-1:0] free_q, take, freed, occupied;
   logic             fire, tok_in_range, mark_en;
   logic [DEPTH-1:0] head_of_entry, finished, clr_mask;
   logic [ID_W-1:0]  ent_id  [DEPTH];
   logic [CNT_W-1:0] ent_cnt [DEPTH];
   logic [ID_W-1:0]  lane_id [LANES];

   always_comb take = CNT_W'(slots_for(int'(alloc_uops), DEPTH));

   assign alloc_ready = (take <= free_q);
   assign fire        = alloc_valid && alloc_ready;
   assign occupied    = CNT_W'(DEPTH) - free_q;

   // Token range filter: free when every index value is a real slot.
   if (DEPTH == (1 << IDX_W)) begin : g_tok_pow2
      assign tok_in_range = 1'b1;
   end else begin : g_tok_clip
      assign tok_in_range = (done_token < IDX_W'(DEPTH));
   end

   assign mark_en = done_valid && tok_in_range &&
                    head_of_entry[done_token] && !finished[done_token];

   retire_ring_store #(
      .DEPTH(DEPTH), .ID_W(ID_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) store_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (fire),
      .wr_idx       (tail_q),
      .wr_id        (alloc_id),
      .wr_cnt       (take),
      .mark_en      (mark_en),
      .mark_idx     (done_token),
      .clr_mask     (clr_mask),
      .head_of_entry(head_of_entry),
      .finished     (finished),
      .ent_id       (ent_id),
      .ent_cnt      (ent_cnt)
   );

   retire_ring_select #(
      .DEPTH(DEPTH), .ID_W(ID_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .LANES(LANES)
   ) select_i (
      .head         (head_q),
      .occupied     (occupied),
      .head_of_entry(head_of_entry),
      .finished     (finished),
      .ent_id       (ent_id),
      .ent_cnt      (ent_cnt),
      .lane_vld     (ret_valid),
      .lane_id      (lane_id),
      .clr_mask     (clr_mask),
      .freed        (freed),
      .head_nxt     (head_nxt)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign ret_id[k*ID_W +: ID_W] = lane_id[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         free_q <= CNT_W'(DEPTH);
      end else begin
         head_q <= head_nxt;
         if (fire) tail_q <= IDX_W'(ring_add(int'(tail_q), int'(take), DEPTH));
         free_q <= free_q - (fire ? take : '0) + freed;
      end
   end

   assign alloc_token = tail_q;
   assign free_slots  = free_q;
   assign empty       = (free_q == CNT_W'(DEPTH));

endmodule

// File: rtl/retire_ring_chk.sv
module retire_ring_chk #(
   parameter int DEPTH      = 12,
   parameter int ID_W       = 8,
   parameter int UOP_W      = 5,
   parameter int RETIRE_MAX = 2,
   localparam int IDX_W     = $clog2(DEPTH),
   localparam int CNT_W     = $clog2(DEPTH + 1),
   localparam int LANES     = (RETIRE_MAX == 0) ? DEPTH : RETIRE_MAX
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  alloc_valid,
   input logic [UOP_W-1:0]      alloc_uops,
   input logic                  alloc_ready,
   input logic [IDX_W-1:0]      alloc_token,
   input logic [LANES-1:0]      ret_valid,
   input logic [CNT_W-1:0]      free_slots,
   input logic                  empty
);

   logic [CNT_W-1:0] chk_take;
   logic [IDX_W-1:0] chk_next_tok;
   logic             chk_fire;

   always_comb begin
      int n;
      int t;
      if (alloc_uops == '0)                 n = 1;
      else if (int'(alloc_uops) > DEPTH)    n = DEPTH;
      else                                  n = int'(alloc_uops);
      t = int'(alloc_token) + n;
      if (t >= DEPTH) t = t - DEPTH;
      chk_take     = CNT_W'(n);
      chk_next_tok = IDX_W'(t);
   end

   assign chk_fire = alloc_valid && alloc_ready;

   assert_free_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      free_slots <= CNT_W'(DEPTH));

   assert_no_retire_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (ret_valid == '0));

   assert_lanes_in_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid & (ret_valid + 1'b1)) == '0);

   assert_empty_accepts_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && alloc_valid) |-> alloc_ready);

   assert_free_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_fire && ret_valid == '0) |=> free_slots == $past(free_slots) - $past(chk_take));

   assert_tail_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      chk_fire |=> alloc_token == $past(chk_next_tok));

   assert_tail_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_fire |=> $stable(alloc_token));

endmodule

bind retire_ring retire_ring_chk #(
   .DEPTH(DEPTH), .ID_W(ID_W), .UOP_W(UOP_W), .RETIRE_MAX(RETIRE_MAX)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .alloc_valid(alloc_valid),
   .alloc_uops (alloc_uops),
   .alloc_ready(alloc_ready),
   .alloc_token(alloc_token),
   .ret_valid  (ret_valid),
   .free_slots (free_slots),
   .empty      (empty)
);

// File: tb/retire_ring_tb_top.sv
module retire_ring_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 12;
   localparam int ID_W       = 8;
   localparam int UOP_W      = 5;
   localparam int RETIRE_MAX = 2;
   localparam int IDX_W      = $clog2(DEPTH);
   localparam int CNT_W      = $clog2(DEPTH + 1);
   localparam int LANES      = (RETIRE_MAX == 0) ? DEPTH : RETIRE_MAX;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  alloc_valid = 1'b0;
   logic [UOP_W-1:0]      alloc_uops = '0;
   logic [ID_W-1:0]       alloc_id = '0;
   logic                  alloc_ready;
   logic [IDX_W-1:0]      alloc_token;
   logic                  done_valid = 1'b0;
   logic [IDX_W-1:0]      done_token = '0;
   logic [LANES-1:0]      ret_valid;
   logic [LANES*ID_W-1:0] ret_id;
   logic [CNT_W-1:0]      free_slots;
   logic                  empty;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished_run = 0;

   // Reference state, indexed by slot as the requirements define tokens.
   bit m_start [DEPTH];
   bit m_exec  [DEPTH];
   int m_id    [DEPTH];
   int m_cnt   [DEPTH];
   int m_head, m_tail, m_free;

   always #(CLK_PERIOD/2) clk = ~clk;

   retire_ring #(
      .DEPTH(DEPTH), .ID_W(ID_W), .UOP_W(UOP_W), .RETIRE_MAX(RETIRE_MAX)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_uops(alloc_uops), .alloc_id(alloc_id),
      .alloc_ready(alloc_ready), .alloc_token(alloc_token),
      .done_valid(done_valid), .done_token(done_token),
      .ret_valid(ret_valid), .ret_id(ret_id),
      .free_slots(free_slots), .empty(empty)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int clamp_uops(input int u);
      if (u == 0) return 1;
      if (u > DEPTH) return DEPTH;
      return u;
   endfunction

   // One cycle: drive, compare outputs with the reference, advance it.
   task automatic step(input bit av, input int uops, input int id, input bit dv, input int tok);
      int e_n, pos, used, n, nl;
      bit e_ready, mark;
      bit e_vld [LANES];
      int e_id  [LANES];
      @(negedge clk);
      alloc_valid = av;
      alloc_uops  = UOP_W'(uops);
      alloc_id    = ID_W'(id);
      done_valid  = dv;
      done_token  = IDX_W'(tok);
      #1;
      n       = clamp_uops(uops);
      e_ready = (n <= m_free);
      check(alloc_ready == e_ready, "R4 alloc_ready", int'(alloc_ready), int'(e_ready));
      check(int'(alloc_token) == m_tail, "R3 alloc_token", int'(alloc_token), m_tail);
      check(int'(free_slots) == m_free, "R5 free_slots", int'(free_slots), m_free);
      check(empty == (m_free == DEPTH), "R10 empty", int'(empty), int'(m_free == DEPTH));
      pos  = m_head;
      used = 0;
      nl   = 0;
      for (int k = 0; k < LANES; k++) begin
         e_vld[k] = 0;
         e_id[k]  = 0;
         if (nl == k && used < DEPTH - m_free && m_start[pos] && m_exec[pos]) begin
            e_vld[k] = 1;
            e_id[k]  = m_id[pos];
            nl++;
            used += m_cnt[pos];
            pos = (pos + m_cnt[pos]) % DEPTH;
         end
      end
      for (int k = 0; k < LANES; k++) begin
         check(ret_valid[k] == e_vld[k], "R7 ret_valid lane", int'(ret_valid[k]), int'(e_vld[k]));
         if (e_vld[k])
            check(int'(ret_id[k*ID_W +: ID_W]) == e_id[k], "R9 ret_id lane",
                  int'(ret_id[k*ID_W +: ID_W]), e_id[k]);
      end
      // Reference update, all from the pre-edge state.
      mark = dv && tok < DEPTH && m_start[tok] && !m_exec[tok];
      pos = m_head;
      for (int k = 0; k < nl; k++) begin
         m_start[pos] = 0;
         m_free += m_cnt[pos];
         pos = (pos + m_cnt[pos]) % DEPTH;
      end
      m_head = pos;
      if (mark) m_exec[tok] = 1;
      if (av && e_ready) begin
         m_start[m_tail] = 1;
         m_exec[m_tail]  = 0;
         m_id[m_tail]    = id % (1 << ID_W);
         m_cnt[m_tail]   = n;
         m_free -= n;
         m_tail = (m_tail + n) % DEPTH;
      end
      @(posedge clk);
      #1;
      alloc_valid = 1'b0;
      done_valid  = 1'b0;
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0);
   endtask

   task automatic drain();
      for (int g = 0; g < 40 && m_free != DEPTH; g++) begin
         int t;
         t = m_head;
         step(0, 0, 0, 1, t);
         idle();
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished_run) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      for (int s = 0; s < DEPTH; s++) begin
         m_start[s] = 0; m_exec[s] = 0; m_id[s] = 0; m_cnt[s] = 0;
      end
      m_head = 0; m_tail = 0; m_free = DEPTH;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(int'(free_slots) == DEPTH, "R1 free after reset", int'(free_slots), DEPTH);
      check(empty == 1'b1, "R1 empty after reset", int'(empty), 1);
      check(alloc_token == '0, "R1 token after reset", int'(alloc_token), 0);
      check(ret_valid == '0, "R1 no retire after reset", int'(ret_valid), 0);

      // R2 zero micro-ops still take one slot
      step(1, 0, 8'h11, 0, 0);
      check(int'(free_slots) == DEPTH - 1, "R2 zero uops slot", int'(free_slots), DEPTH - 1);
      // R4 oversize request does not fit and leaves no trace
      step(1, 20, 8'h22, 0, 0);
      check(int'(free_slots) == DEPTH - 1, "R4 refused keeps free", int'(free_slots), DEPTH - 1);
      check(int'(alloc_token) == 1, "R4 refused keeps token", int'(alloc_token), 1);
      step(1, 3, 8'h33, 0, 0);
      step(1, 2, 8'h44, 0, 0);
      // R7 younger completion alone does not retire
      step(0, 0, 0, 1, 4);
      check(ret_valid == '0, "R7 blocked by older", int'(ret_valid), 0);
      // R6 repeated, mid-entry and out-of-range reports ignored
      step(0, 0, 0, 1, 4);
      step(0, 0, 0, 1, 2);
      step(0, 0, 0, 1, 14);
      check(ret_valid == '0, "R6 bogus reports ignored", int'(ret_valid), 0);
      step(0, 0, 0, 1, 0);
      check(ret_valid == 2'b01, "R7 head only", int'(ret_valid), 1);
      idle();
      step(0, 0, 0, 1, 1);
      check(ret_valid == 2'b11, "R8 two lanes", int'(ret_valid), 3);
      check(ret_id[ID_W +: ID_W] == 8'h44, "R9 lane1 id", int'(ret_id[ID_W +: ID_W]), 'h44);
      idle();
      check(empty == 1'b1, "R10 empty after drain", int'(empty), 1);
      // R8 limit with three completed single-slot entries
      step(1, 1, 8'h51, 0, 0);
      step(1, 1, 8'h52, 0, 0);
      step(1, 1, 8'h53, 0, 0);
      step(0, 0, 0, 1, m_tail == 0 ? DEPTH - 1 : m_tail - 1);
      step(0, 0, 0, 1, (m_tail + DEPTH - 2) % DEPTH);
      step(0, 0, 0, 1, (m_tail + DEPTH - 3) % DEPTH);
      check($countones(ret_valid) == RETIRE_MAX, "R8 limit held", $countones(ret_valid), RETIRE_MAX);
      drain();
      // R2 oversize clamps to the whole ring when empty
      step(1, 25, 8'h66, 0, 0);
      check(free_slots == '0, "R2 oversize clamp", int'(free_slots), 0);
      step(1, 0, 8'h67, 0, 0);
      check(free_slots == '0, "R4 full refuses", int'(free_slots), 0);
      drain();

      // Constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         int u, tok, off;
         bit av, dv;
         av  = ($urandom % 4) != 0;
         u   = ($urandom % 8 == 0) ? $urandom % 32 : $urandom % 5;
         dv  = ($urandom % 3) != 0;
         tok = $urandom % 16;
         if ($urandom % 2 == 0) begin
            off = $urandom % DEPTH;
            for (int j = 0; j < DEPTH; j++)
               if (m_start[(off + j) % DEPTH] && !m_exec[(off + j) % DEPTH]) begin
                  tok = (off + j) % DEPTH;
                  break;
               end
         end
         step(av, u, $urandom % 256, dv, tok);
      end
      drain();
      check(empty == 1'b1, "R10 empty at end", int'(empty), 1);

      finished_run = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule